// File: doc/BRIEF.md
# Fall-Through Receive Byte Buffer

This block holds the bytes a high-speed serial receiver has finished deserializing until software picks them up. Each completed byte arrives with a one-cycle strobe and enters the top stage of a chain of byte-wide stages. Every stage keeps its own valid bit. A byte steps one stage toward the output slot on each clock in which the stage below it is empty, so bytes fall through the chain and pile up at the bottom in arrival order. The bottom stage is the data register that software reads. A read strobe empties that slot, and the byte above it drops in on the following clock.

A mode input selects between buffered operation, which uses the whole chain, and single-register operation. In single-register mode each new byte goes straight into the output slot and the rest of the chain is not used. The status word reports whether the output slot holds an unread byte, whether the chain is full or empty, and a sticky overrun flag. Software polls the ready bit before it reads, so it never picks up a stale byte. A change of mode or a reset empties the buffer and clears the overrun flag.

Top module: `rx_fallthru_buf`

## Requirements
- R1: In buffered mode (`fifo_mode_i`=1) the buffer holds 32 bytes. A byte that arrives when all 32 stages are valid is dropped. The first 32 bytes still come out intact and in order.
- R2: In buffered mode a byte written into an empty buffer becomes readable exactly 32 rising clock edges after the edge that captures it, counting that edge. Bytes leave the buffer in the order they arrived.
- R3: In buffered mode a byte that arrives while the top stage is still valid is dropped and sets the overrun flag. This includes a byte that arrives on the cycle directly after an accepted one.
- R4: In single-register mode (`fifo_mode_i`=0) a byte is placed in the output slot on the next edge. If the slot already holds an unread byte and no read happens in the same cycle, the new byte is dropped, the overrun flag is set, and the old byte stays.
- R5: `rd_data_o[7:0]` shows the byte in the output slot. `rd_data_o[31:8]` always reads zero.
- R6: The ready bit, `status_o[14]`, is 1 exactly when the output slot holds an unread byte. A read clears it. A read while the bit is 0 changes nothing.
- R7: When a byte arrives and a read is issued in the same cycle, both take effect, in either mode. The read returns the old byte, the new byte is kept, and no overrun is flagged.
- R8: The overrun flag, `status_o[0]`, is sticky. A pulse on `ovr_clr_i` clears it. If a drop happens in the same cycle as the clear, the flag stays set.
- R9: The full bit, `status_o[1]`, is 1 when all 32 stages are valid. The empty bit, `status_o[2]`, is 1 when no stage is valid. All other status bits read zero.
- R10: A change of `fifo_mode_i` empties every stage and clears the overrun flag on the next edge. A byte that arrives in the cycle of the change is ignored.
- R11: While `rst_n` is low, every stage is empty and the overrun flag is cleared, so the status word reads 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | 1 = buffered chain, 0 = single output register |
| byte_vld_i | input | 1 | One-cycle strobe: a received byte is on `byte_i` |
| byte_i | input | 8 | Received byte |
| rd_i | input | 1 | Read strobe of the data register |
| ovr_clr_i | input | 1 | Clear pulse for the overrun flag (a status write with 1 in bit 0) |
| rd_data_o | output | 32 | Data register: output byte in [7:0], zero above |
| status_o | output | 16 | Status word: bit 0 overrun, bit 1 full, bit 2 empty, bit 14 ready |

## Verification
The bench measures the fall-through latency to the exact edge, 31 edges not ready and 32 edges ready. A chain that skips or stalls a stage misses that count by one. It sends two bytes on consecutive cycles. A design that counts the top stage as free while its byte is leaving would accept both instead of dropping the second and flagging overrun. It issues a read in the same cycle as a write in both modes. A design that lets the read cancel the write, or treats the slot as occupied, would lose a byte or raise a false overrun. It also checks that a clear pulse loses to a drop in the same cycle, and that a byte arriving during a mode change is ignored. A design that got either wrong would show a cleared flag, or a ready byte, that should not exist.

// File: rtl/rx_fallthru_pkg.sv
package rx_fallthru_pkg;

  localparam int unsigned FT_DEPTH  = 32;
  localparam int unsigned FT_DATA_W = 8;
  localparam int unsigned FT_BUS_W  = 32;
  localparam int unsigned FT_STAT_W = 16;

  // status word bit positions
  localparam int unsigned ST_OVR   = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_EMPTY = 2;
  localparam int unsigned ST_READY = 14;

  // next valid bit of one stage: flush wins, then load fills, drain empties
  function automatic logic next_vld(input logic cur, input logic load,
                                    input logic drain, input logic flush);
    return flush ? 1'b0 : ((cur & ~drain) | load);
  endfunction

  // sticky overrun: a drop beats a clear, a flush beats both
  function automatic logic next_ovr(input logic cur, input logic drop,
                                    input logic clr, input logic flush);
    return flush ? 1'b0 : (drop | (cur & ~clr));
  endfunction

  function automatic logic [FT_STAT_W-1:0] pack_status(input logic ovr,
      input logic full, input logic empty, input logic ready);
    logic [FT_STAT_W-1:0] s;
    s           = '0;
    s[ST_OVR]   = ovr;
    s[ST_FULL]  = full;
    s[ST_EMPTY] = empty;
    s[ST_READY] = ready;
    return s;
  endfunction

endpackage

// File: rtl/rx_ft_stage.sv
module rx_ft_stage
  import rx_fallthru_pkg::*;
#(
  parameter int unsigned DATA_W = FT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drain_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= next_vld(vld_o, load_i, drain_i, flush_i);
  end

  // payload needs no reset: it is only observed while vld_o is set
  always_ff @(posedge clk) begin
    if (load_i) data_o <= load_data_i;
  end

  // R2: a byte only falls into a stage that is empty or being emptied
  p_load_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!vld_o || drain_i));

endmodule

// File: rtl/rx_ft_ctrl.sv
module rx_ft_ctrl
  import rx_fallthru_pkg::*;
#(
  parameter bit RST_MODE_BUF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic byte_vld_i,
  input  logic rd_i,
  input  logic ovr_clr_i,
  input  logic head_vld_i,
  input  logic tail_vld_i,
  output logic mode_buf_o,
  output logic flush_o,
  output logic buf_acc_o,
  output logic nb_acc_o,
  output logic rd_take_o,
  output logic drop_o,
  output logic ovr_o
);

  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RST_MODE_BUF;
    else        mode_q <= mode_i;
  end

  assign mode_buf_o = mode_q;
  assign flush_o    = mode_i ^ mode_q;

  // named events for the datapath and the assertions
  assign rd_take_o = rd_i & tail_vld_i & ~flush_o;
  assign buf_acc_o = mode_q & byte_vld_i & ~head_vld_i & ~flush_o;
  assign nb_acc_o  = ~mode_q & byte_vld_i & (~tail_vld_i | rd_i) & ~flush_o;
  assign drop_o    = byte_vld_i & ~flush_o & ~buf_acc_o & ~nb_acc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_o <= 1'b0;
    else        ovr_o <= next_ovr(ovr_o, drop_o, ovr_clr_i, flush_o);
  end

  // R3: every dropped byte leaves the overrun flag set
  p_drop_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> ovr_o);

  // R8: only a clear or a flush can lower the flag
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr_i && !flush_o) |=> ovr_o);

  // R10: a mode change clears the overrun flag
  p_flush_clr_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !ovr_o);

  // R7: a write never gets dropped when a read frees the slot in single mode
  p_rdwr_no_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !flush_o && byte_vld_i && rd_take_o) |-> !drop_o);

endmodule

// File: rtl/rx_fallthru_buf.sv
module rx_fallthru_buf
  import rx_fallthru_pkg::*;
#(
  parameter int unsigned DEPTH        = FT_DEPTH,
  parameter int unsigned DATA_W       = FT_DATA_W,
  parameter int unsigned BUS_W        = FT_BUS_W,
  parameter bit          RST_MODE_BUF = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fifo_mode_i,
  input  logic                 byte_vld_i,
  input  logic [DATA_W-1:0]    byte_i,
  input  logic                 rd_i,
  input  logic                 ovr_clr_i,
  output logic [BUS_W-1:0]     rd_data_o,
  output logic [FT_STAT_W-1:0] status_o
);

  localparam int unsigned LAST  = DEPTH - 1;
  localparam int unsigned PAD_W = BUS_W - DATA_W;

  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] dat [DEPTH];
  logic [DEPTH-2:0]  move;

  logic mode_buf, flush, buf_acc, nb_acc, rd_take, drop, ovr;
  logic full, empty, ready;

  rx_ft_ctrl #(.RST_MODE_BUF(RST_MODE_BUF)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (fifo_mode_i),
    .byte_vld_i (byte_vld_i),
    .rd_i       (rd_i),
    .ovr_clr_i  (ovr_clr_i),
    .head_vld_i (vld[0]),
    .tail_vld_i (vld[LAST]),
    .mode_buf_o (mode_buf),
    .flush_o    (flush),
    .buf_acc_o  (buf_acc),
    .nb_acc_o   (nb_acc),
    .rd_take_o  (rd_take),
    .drop_o     (drop),
    .ovr_o      (ovr)
  );

  // a byte steps down when the stage below holds nothing
  for (genvar k = 0; k < LAST; k++) begin : g_move
    assign move[k] = mode_buf & ~flush & vld[k] & ~vld[k+1];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic              ld;
    logic              dr;
    logic [DATA_W-1:0] ld_d;

    if (k == 0) begin : g_head
      assign ld   = buf_acc;
      assign ld_d = byte_i;
    end else if (k == LAST) begin : g_tail
      assign ld   = move[k-1] | nb_acc;
      assign ld_d = mode_buf ? dat[k-1] : byte_i;
    end else begin : g_mid
      assign ld   = move[k-1];
      assign ld_d = dat[k-1];
    end

    if (k == LAST) begin : g_rd
      assign dr = rd_take;
    end else begin : g_mv
      assign dr = move[k];
    end

    rx_ft_stage #(.DATA_W(DATA_W)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush),
      .load_i      (ld),
      .load_data_i (ld_d),
      .drain_i     (dr),
      .vld_o       (vld[k]),
      .data_o      (dat[k])
    );
  end

  assign full      = &vld;
  assign empty     = ~|vld;
  assign ready     = vld[LAST];
  assign rd_data_o = {{PAD_W{1'b0}}, dat[LAST]};
  assign status_o  = pack_status(ovr, full, empty, ready);

  // R6: a read of a ready slot in buffered mode leaves it not ready for a cycle
  p_ready_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_buf && !flush && rd_i && ready) |=> !ready);

  // R9: full and empty never hold together
  p_full_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R10: a mode change leaves every stage empty
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R4: single mode places an accepted byte in the output slot at once
  p_nb_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nb_acc |=> (ready && rd_data_o[DATA_W-1:0] == $past(byte_i)));

  // R1: nothing is accepted into a full chain
  p_full_no_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && byte_vld_i && mode_buf) |-> !buf_acc);

endmodule

// File: tb/rx_fallthru_buf_tb_top.sv
module rx_fallthru_buf_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode_i = 1'b1;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        rd_i = 1'b0;
  logic        ovr_clr_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [15:0] status_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  rx_fallthru_buf dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_i(rd_i),
    .ovr_clr_i(ovr_clr_i), .rd_data_o(rd_data_o), .status_o(status_o)
  );

  // status layout from the requirements: 0 overrun, 1 full, 2 empty, 14 ready
  function automatic logic [15:0] exp_stat(input bit ovr, input bit full,
                                           input bit empty, input bit ready);
    return {1'b0, ready, 11'd0, empty, full, ovr};
  endfunction

  // table: [15] mode, [14:9] byte count, [8:1] first byte, [0] overrun expected
  localparam logic [15:0] TBL [5] = '{
    {1'b1, 6'd1,  8'h3C, 1'b0},
    {1'b1, 6'd32, 8'h10, 1'b0},
    {1'b1, 6'd35, 8'hA0, 1'b1},
    {1'b0, 6'd1,  8'h55, 1'b0},
    {1'b0, 6'd3,  8'hE1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    fifo_mode_i = m;
    @(negedge clk);
  endtask

  task automatic clr_ovr();
    ovr_clr_i = 1'b1;
    @(negedge clk);
    ovr_clr_i = 1'b0;
  endtask

  // poll ready like software, then read once
  task automatic rd_one(input string req, output logic [7:0] b);
    int wait_n = 0;
    while (!status_o[14] && wait_n < 100) begin
      @(negedge clk); wait_n++;
    end
    check({req, " ready before read"}, 32'(status_o[14]), 32'd1);
    b = rd_data_o[7:0];
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle(3);
    // R11 R9 R5: reset state
    check("R11 reset status", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));
    check("R5 upper bits at reset", rd_data_o[31:8], 32'd0);
    rst_n = 1'b1;
    idle(2);

    // table walk: fill, check flags, drain in order
    for (int e = 0; e < 5; e++) begin
      bit       m    = TBL[e][15];
      int       cnt  = int'(TBL[e][14:9]);
      logic [7:0] sd = TBL[e][8:1];
      bit       eo   = TBL[e][0];
      int       nout;
      set_mode(m);
      clr_ovr();
      for (int i = 0; i < cnt; i++) begin
        wr_byte(8'(sd + 8'(i)));
        idle(36);
      end
      nout = m ? ((cnt > 32) ? 32 : cnt) : 1;
      check("R1 R9 full flag", 32'(status_o[1]), 32'(m && cnt >= 32));
      check("R3 R4 overrun flag", 32'(status_o[0]), 32'(eo));
      for (int j = 0; j < nout; j++) begin
        rd_one("R2", got);
        check("R2 R1 R4 order", 32'(got), 32'(8'(sd + 8'(j))));
      end
      idle(2);
      check("R9 R6 empty after drain", 32'(status_o[2:1]) | 32'(status_o[14]) << 4,
            32'h2);
    end

    // R2: exact fall-through latency
    set_mode(1'b1); clr_ovr();
    wr_byte(8'h6B);
    idle(30);
    check("R2 not ready at 31 edges", 32'(status_o[14]), 32'd0);
    idle(1);
    check("R2 ready at 32 edges", 32'(status_o[14]), 32'd1);
    check("R5 data word", rd_data_o, 32'h0000006B);
    rd_one("R6", got);
    check("R6 ready cleared by read", 32'(status_o[14]), 32'd0);

    // R3: back-to-back bytes, second dropped
    idle(3);
    byte_vld_i = 1'b1; byte_i = 8'h11;
    @(negedge clk);
    byte_i = 8'h22;
    @(negedge clk);
    byte_vld_i = 1'b0;
    check("R3 overrun on busy top stage", 32'(status_o[0]), 32'd1);
    idle(36);
    rd_one("R3", got);
    check("R3 first byte kept", 32'(got), 32'h11);
    idle(36);
    check("R3 second byte dropped", 32'(status_o), 32'(exp_stat(1, 0, 1, 0)));
    clr_ovr();

    // R7: buffered write and read in the same cycle
    wr_byte(8'h81); idle(36);
    byte_vld_i = 1'b1; byte_i = 8'h82; rd_i = 1'b1;
    got = rd_data_o[7:0];
    @(negedge clk);
    byte_vld_i = 1'b0; rd_i = 1'b0;
    check("R7 buffered read returns old", 32'(got), 32'h81);
    idle(36);
    rd_one("R7", got);
    check("R7 buffered new byte kept", 32'(got), 32'h82);
    check("R7 buffered no overrun", 32'(status_o[0]), 32'd0);

    // R4: single-register placement and drop
    set_mode(1'b0);
    wr_byte(8'hC1);
    check("R4 placed after one edge", 32'(status_o[14]), 32'd1);
    check("R4 placed data", rd_data_o, 32'h000000C1);
    wr_byte(8'hC2);
    check("R4 drop sets overrun", 32'(status_o[0]), 32'd1);
    check("R4 old byte kept", rd_data_o, 32'h000000C1);
    clr_ovr();
    check("R8 clear pulse", 32'(status_o[0]), 32'd0);

    // R7: single-register write and read in the same cycle
    byte_vld_i = 1'b1; byte_i = 8'hC3; rd_i = 1'b1;
    got = rd_data_o[7:0];
    @(negedge clk);
    byte_vld_i = 1'b0; rd_i = 1'b0;
    check("R7 single read returns old", 32'(got), 32'hC1);
    check("R7 single new byte placed", rd_data_o, 32'h000000C3);
    check("R7 single no overrun", 32'(status_o[0]), 32'd0);

    // R8: a drop wins over a clear in the same cycle
    byte_vld_i = 1'b1; byte_i = 8'hC4; ovr_clr_i = 1'b1;
    @(negedge clk);
    byte_vld_i = 1'b0; ovr_clr_i = 1'b0;
    check("R8 drop beats clear", 32'(status_o[0]), 32'd1);
    idle(3);
    check("R8 flag sticky", 32'(status_o[0]), 32'd1);
    clr_ovr();
    rd_one("R8", got);
    check("R8 slot unchanged by drop", 32'(got), 32'hC3);

    // R6: a read of an empty slot changes nothing
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    check("R6 empty read no effect", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));

    // R10: mode change flushes, a byte in that cycle is ignored
    wr_byte(8'hD0);
    wr_byte(8'hD1);
    check("R10 setup overrun", 32'(status_o), 32'(exp_stat(1, 0, 0, 1)));
    fifo_mode_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hD2;
    @(negedge clk);
    byte_vld_i = 1'b0;
    check("R10 flush clears all", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));
    idle(36);
    check("R10 byte in change cycle ignored", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));

    // R11: reset in the middle of traffic
    wr_byte(8'hE0); idle(3); wr_byte(8'hE1);
    wr_byte(8'hE2);
    rst_n = 1'b0;
    idle(2);
    check("R11 mid-run reset", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));
    rst_n = 1'b1;
    idle(36);
    check("R11 stays empty after reset", 32'(status_o), 32'(exp_stat(0, 0, 1, 0)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule